// File: doc/BRIEF.md
# Quarter-wave DDS sine generator

This block is a direct digital synthesis core that turns a 16-bit frequency word into a stream of 8-bit sine samples for a unipolar DAC. A phase accumulator of 21 bits advances once every fourth system clock by the zero-extended frequency word, so the output frequency is the clock frequency times the word over 2^23. The finest step is the clock frequency over 2^23. A word of zero holds the phase and gives a DC level.

The top bits of the phase choose the half-cycle (sign), the quarter (quadrant) and a 7-bit table address. One table of 128 magnitudes covers a quarter wave, sampled at the centre of each step. Mirroring the address in odd quarters and complementing the magnitude in the negative half make a 512-point wave out of it. Each sample is registered and marked by a one-cycle valid strobe. A power-down request clears the phase and parks the output at mid-scale.

The update cadence is kept by a small state machine with three states. ST_DOWN is held during reset and power-down. ST_WAIT counts idle clocks. ST_STEP is the single update cycle. Its transitions are: ST_DOWN to ST_WAIT when power-down is low. ST_WAIT to ST_STEP when the idle count completes. ST_STEP back to ST_WAIT. Any state goes to ST_DOWN when power-down is high.

Top module: `dds_sine_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sample` is 8'h80 and `sample_valid` is 0.
- R2: `sample_valid` pulses for one cycle in every 4. The first pulse follows the 4th rising edge at which reset and power-down are both low.
- R3: At each update, the 21-bit phase grows by the zero-extended frequency word, modulo 2^21. Between updates it holds. With word 16'h8000 the output repeats after 64 updates.
- R4: Phase bit 20 is the sign and bit 19 is the quadrant. Bits 18:12 are the table address, and bits 11:0 do not affect the sample. With word 16'h0800, the first update gives 8'h81 and the second gives 8'h82.
- R5: When the quadrant bit is 1, the table address is bit-inverted before lookup. Phase 0x07F000 and phase 0x080000 both give 8'hFF.
- R6: Table entry i holds round(127·sin((i+0.5)·π/256)), so entry 0 is 1, entry 1 is 2 and entry 127 is 127.
- R7: The output code is offset binary: {~sign, sign ? ~mag : mag}. A full cycle therefore reaches 8'hFF at its maximum and 8'h00 at its minimum, and phase 0x100000 gives 8'h7E.
- R8: `sample` changes only in the cycle where `sample_valid` is high, or on a power-down or reset.
- R9: With a frequency word of zero, every update gives the same code (8'h81 from a cleared phase).
- R10: One cycle after `pd_req` is high, `sample` is 8'h80, `sample_valid` is 0 and the phase is 0. After release, the output restarts from phase 0.
- R11: The frequency word is taken only at the update edge. A change between updates first shows at the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_req | input | 1 | Power-down request, active high |
| freq_word | input | 16 | Phase increment per update |
| sample | output | 8 | Registered offset-binary sine code |
| sample_valid | output | 1 | High for the cycle a new sample appears |

## Verification
The bound checker watches several rules on every cycle. It checks the one-in-four strobe cadence against its own counter. It checks that the phase moves by exactly the previous word at each strobe and holds otherwise. It also checks the hold of the sample between strobes, the mid-scale and cleared phase after power-down, and that the code MSB is the inverted sign bit. The table contents, the quadrant mirror, the extremes of a full cycle and the restart after power-down release involve the sine values themselves. Only the bench's scenarios can show those, comparing each strobed sample with an independently computed expected code and with fixed codes at chosen phases.

// File: rtl/dds_sine_pkg.sv
package dds_sine_pkg;

    // Update-cadence states
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_WAIT = 2'd1,
        ST_STEP = 2'd2
    } tick_state_e;

    // Code that represents 0 V on the unipolar DAC
    localparam logic [7:0] MID_CODE = 8'h80;

endpackage

// File: rtl/dds_tick_fsm.sv
// Produces one update strobe every TICK_DIV clocks (TICK_DIV >= 3).
module dds_tick_fsm
    import dds_sine_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    output logic tick
);
    localparam int CNT_W = $clog2(TICK_DIV);
    localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(TICK_DIV - 2);

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DOWN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_DOWN: begin
                // entry cycle counts as the first of the period
                state_d = ST_WAIT;
                cnt_d   = CNT_W'(1);
            end
            ST_WAIT: begin
                if (cnt_q == LAST_IDLE) begin
                    state_d = ST_STEP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STEP: begin
                state_d = ST_WAIT;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_DOWN;
                cnt_d   = '0;
            end
        endcase
        if (pd_req) begin
            state_d = ST_DOWN;
            cnt_d   = '0;
        end
    end

    // Outputs
    always_comb begin
        tick = (state_q == ST_STEP);
    end

endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator with zero-extended increment; exposes the
// post-update top bits used for lookup.
module dds_phase_acc #(
    parameter int FW_W   = 16,
    parameter int ACC_W  = 21,
    parameter int LOOK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [FW_W-1:0]   fw,
    output logic [ACC_W-1:0]  acc_q,
    output logic [LOOK_W-1:0] nxt_top
);
    localparam int EXT_W = ACC_W - FW_W;

    logic [ACC_W-1:0] acc_nxt;

    always_comb begin
        acc_nxt = acc_q + {{EXT_W{1'b0}}, fw};
        nxt_top = acc_nxt[ACC_W-1 -: LOOK_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/dds_quarter_rom.sv
// Quarter-wave magnitude table, computed at elaboration.
// Entry i = round(AMP * sin((i + 0.5) * pi / (2 * DEPTH))).
module dds_quarter_rom #(
    parameter int ADDR_W = 7,
    parameter int MAG_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MAG_W-1:0]  mag
);
    localparam int  DEPTH = 1 << ADDR_W;
    localparam real PI_R  = 3.14159265358979;
    localparam real AMP   = real'((1 << MAG_W) - 1);

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam real ANG = (real'(i) + 0.5) * PI_R / real'(2 * DEPTH);
        localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
        assign tbl[i] = MAG_W'(VAL);
    end

    assign mag = tbl[addr];

endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core
    import dds_sine_pkg::*;
#(
    parameter int FW_W     = 16,
    parameter int ACC_W    = 21,
    parameter int ADDR_W   = 7,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_req,
    input  logic [FW_W-1:0]   freq_word,
    output logic [7:0]        sample,
    output logic              sample_valid
);
    localparam int MAG_W  = 7;
    localparam int OUT_W  = MAG_W + 1;
    localparam int LOOK_W = ADDR_W + 2;

    logic              tick;
    logic [ACC_W-1:0]  phase_q;
    logic [LOOK_W-1:0] look;
    logic              sgn, quad;
    logic [ADDR_W-1:0] raw_addr, rom_addr;
    logic [MAG_W-1:0]  mag;
    logic [OUT_W-1:0]  code;

    dds_tick_fsm #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .pd_req (pd_req),
        .tick   (tick)
    );

    dds_phase_acc #(.FW_W(FW_W), .ACC_W(ACC_W), .LOOK_W(LOOK_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (pd_req),
        .step    (tick),
        .fw      (freq_word),
        .acc_q   (phase_q),
        .nxt_top (look)
    );

    // Field split and quadrant complementer
    always_comb begin
        sgn      = look[LOOK_W-1];
        quad     = look[LOOK_W-2];
        raw_addr = look[ADDR_W-1:0];
        rom_addr = quad ? ~raw_addr : raw_addr;
    end

    dds_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .addr (rom_addr),
        .mag  (mag)
    );

    // Sign complementer, offset-binary packing
    always_comb begin
        code = {~sgn, (sgn ? ~mag : mag)};
    end

    // Output latch at the update rate
    always_ff @(posedge clk) begin
        if (rst || pd_req) begin
            sample       <= MID_CODE;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= tick;
            if (tick) begin
                sample <= code;
            end
        end
    end

endmodule

// File: rtl/dds_sine_core_chk.sv
module dds_sine_core_chk
    import dds_sine_pkg::*;
#(
    parameter int FW_W     = 16,
    parameter int ACC_W    = 21,
    parameter int TICK_DIV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             pd_req,
    input logic [FW_W-1:0]  freq_word,
    input logic [7:0]       sample,
    input logic             sample_valid,
    input logic [ACC_W-1:0] phase_q
);
    localparam int GAP_W = $clog2(TICK_DIV + 1);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(TICK_DIV);

    // Edges since reset/power-down, wrapping 1..TICK_DIV
    logic [GAP_W-1:0] gap;
    always_ff @(posedge clk) begin
        if (rst || pd_req) gap <= '0;
        else if (gap == GAP_END) gap <= GAP_W'(1);
        else gap <= gap + 1'b1;
    end

    AST_VALID_CADENCE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (gap == GAP_END)); // R2
    AST_VALID_DUE: assert property (@(posedge clk) disable iff (rst)
        (gap == GAP_END) |-> sample_valid); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (phase_q == ACC_W'($past(phase_q) + ACC_W'($past(freq_word))))); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !$past(pd_req)) |-> $stable(phase_q)); // R3
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !$past(pd_req)) |-> $stable(sample)); // R8
    AST_PD_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        $past(pd_req) |-> (sample == MID_CODE && !sample_valid)); // R10
    AST_PD_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(pd_req) |-> (phase_q == '0)); // R10
    AST_CODE_MSB: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (sample[7] == ~phase_q[ACC_W-1])); // R7

endmodule

bind dds_sine_core dds_sine_core_chk #(
    .FW_W(FW_W), .ACC_W(ACC_W), .TICK_DIV(TICK_DIV)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pd_req       (pd_req),
    .freq_word    (freq_word),
    .sample       (sample),
    .sample_valid (sample_valid),
    .phase_q      (phase_q)
);

// File: tb/dds_sine_core_bench.sv
module dds_sine_core_bench;

    localparam real PI_R = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_req = 1'b0;
    logic [15:0] freq_word = 16'h0;
    logic [7:0]  sample;
    logic        sample_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    logic [20:0] m_phase = '0;
    int          m_cnt   = 0;
    logic [7:0]  m_prev  = 8'h80;
    logic        m_tick  = 1'b0;
    int          tick_no = 0;

    always #4 clk = ~clk;

    dds_sine_core u_dds_sine_core (
        .clk          (clk),
        .rst          (rst),
        .pd_req       (pd_req),
        .freq_word    (freq_word),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    // Expected code from the requirement text (R4..R7)
    function automatic logic [7:0] ref_code(input logic [20:0] p);
        int         a;
        int         m;
        logic [6:0] m7;
        a = int'(p[18:12]);
        if (p[19]) a = 127 - a;
        m  = $rtoi(127.0 * $sin((real'(a) + 0.5) * PI_R / 256.0) + 0.5);
        m7 = m[6:0];
        return p[20] ? {1'b0, ~m7} : {1'b1, m7};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: note inputs at the edge, compare outputs at the falling edge
    task automatic cyc(input string req);
        logic [15:0] fw_e;
        logic        pd_e, rst_e, exp_v;
        logic [7:0]  exp_s;
        @(posedge clk);
        fw_e = freq_word; pd_e = pd_req; rst_e = rst;
        @(negedge clk);
        if (rst_e || pd_e) begin
            m_phase = '0; m_cnt = 0; exp_v = 1'b0; exp_s = 8'h80;
        end else begin
            m_cnt = (m_cnt == 4) ? 1 : m_cnt + 1;
            exp_v = (m_cnt == 4);
            if (exp_v) begin
                m_phase = m_phase + {5'b0, fw_e};
                exp_s   = ref_code(m_phase);
                tick_no++;
            end else begin
                exp_s = m_prev;
            end
        end
        chk(sample_valid == exp_v, "R2 strobe", int'(sample_valid), int'(exp_v));
        chk(sample == exp_s, req, int'(sample), int'(exp_s));
        m_prev = exp_s;
        m_tick = exp_v;
    endtask

    task automatic run_ticks(input int n, input string req);
        int start;
        start = tick_no;
        while (tick_no - start < n) cyc(req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R1 during reset");
        rst = 1'b0;
        cyc("R1 first cycle after reset");
        chk(sample == 8'h80 && !sample_valid, "R1 idle output", int'(sample), 8'h80);
        tick_no = 0;
    endtask

    task automatic t_dc;
        freq_word = 16'h0;
        t_reset();
        run_ticks(10, "R9 zero word");
        chk(sample == 8'h81, "R9 DC level", int'(sample), 8'h81);
    endtask

    task automatic t_sweep;
        int lo, hi;
        lo = 255; hi = 0;
        freq_word = 16'h1000;
        t_reset();
        while (tick_no < 512) begin
            cyc("R7 full cycle");
            if (m_tick) begin
                if (int'(sample) < lo) lo = int'(sample);
                if (int'(sample) > hi) hi = int'(sample);
                if (tick_no == 1)   chk(sample == 8'h82, "R6 entry 1", int'(sample), 8'h82);
                if (tick_no == 127) chk(sample == 8'hFF, "R5 phase 0x07F000", int'(sample), 8'hFF);
                if (tick_no == 128) chk(sample == 8'hFF, "R5 phase 0x080000 mirrored", int'(sample), 8'hFF);
                if (tick_no == 256) chk(sample == 8'h7E, "R7 phase 0x100000", int'(sample), 8'h7E);
                if (tick_no == 384) chk(sample == 8'h00, "R5 phase 0x180000", int'(sample), 8'h00);
                if (tick_no == 512) chk(sample == 8'h81, "R3 wrap to 0", int'(sample), 8'h81);
            end
        end
        chk(hi == 255, "R7 maximum code", hi, 255);
        chk(lo == 0, "R7 minimum code", lo, 0);
    endtask

    task automatic t_low_bits;
        freq_word = 16'h0800;
        t_reset();
        run_ticks(1, "R4 half step");
        chk(sample == 8'h81, "R4 bits 11:0 ignored", int'(sample), 8'h81);
        run_ticks(1, "R4 full step");
        chk(sample == 8'h82, "R4 address advances", int'(sample), 8'h82);
    endtask

    task automatic t_period;
        freq_word = 16'h8000;
        t_reset();
        run_ticks(64, "R3 coarse word");
        chk(sample == 8'h81, "R3 period of 64 updates", int'(sample), 8'h81);
        freq_word = 16'hFFFF;
        run_ticks(300, "R3 largest word");
    endtask

    task automatic t_power_down;
        int wait_n;
        freq_word = 16'h1234;
        t_reset();
        run_ticks(7, "R10 before power-down");
        pd_req = 1'b1;
        for (int i = 0; i < 6; i++) cyc("R10 power-down");
        chk(sample == 8'h80 && !sample_valid, "R10 mid-scale", int'(sample), 8'h80);
        pd_req = 1'b0;
        freq_word = 16'h1000;
        wait_n = 0;
        tick_no = 0;
        while (tick_no < 1) begin cyc("R10 restart"); wait_n++; end
        chk(wait_n == 4, "R2 first strobe after release", wait_n, 4);
        chk(sample == 8'h82, "R10 restart from phase 0", int'(sample), 8'h82);
    endtask

    task automatic t_word_change;
        freq_word = 16'h0400;
        t_reset();
        run_ticks(3, "R11 first word");
        cyc("R11 between updates");
        freq_word = 16'h3000;
        cyc("R11 between updates");
        freq_word = 16'h5A00;
        run_ticks(20, "R11 changed word");
    endtask

    initial begin
        t_reset();
        t_dc();
        t_sweep();
        t_low_bits();
        t_period();
        t_power_down();
        t_word_change();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule